// File: doc/BRIEF.md
# Packed Single-to-Half Precision Narrowing Converter

This block narrows packed IEEE 754 single-precision values (8-bit exponent, 23-bit fraction) to half precision (5-bit exponent biased by 15, 10-bit fraction). One of four rounding directions is applied. A request carries a source vector, a width select, an 8-bit immediate with an enable, a 2-bit default rounding field and the previous contents of the destination. One clock later the block returns the narrowed destination, or a reserved-encoding indication in its place.

The rounding direction can come from two places. When the immediate is enabled, its low bits choose the direction for that request alone. Otherwise the default field chooses it. The block never changes the default field. In narrow mode only the low half of the lanes is converted, and the upper half of the destination is merged back from the previous value. In wide mode every lane is converted.

Each lane handles overflow as its rounding direction requires. Results below the half-precision normal range are shifted into subnormals, and rounding may carry up to the smallest normal. NaN and infinity inputs pass through with their class kept.

Top module: `f2h_narrow`

## Requirements
- R1: Rounding code 0 rounds to nearest, and an exact tie goes to the value whose lowest fraction bit is 0. For example, 0x3F801000 gives 0x3C00 and 0x3F803000 gives 0x3C02.
- R2: Code 1 truncates toward zero. Code 2 rounds toward negative infinity. Code 3 rounds toward positive infinity. A directed code raises the magnitude by one unit only when discarded bits are non-zero and the sign points in that code's direction.
- R3: When `imm_en` is 1, `imm[1:0]` selects the rounding code and `rc_dflt` is ignored. When `imm_en` is 0, `rc_dflt` selects the code and `imm` is ignored, including reserved values. `imm[7:5]` never affects the result.
- R4: When `imm_en` is 1 and `imm[4:0]` is between 4 and 31, the next cycle shows `bad_imm`=1 and `out_valid`=0, and `dst` keeps its previous value.
- R5: With `wide`=0, lane i (i = 0..3) is taken from `src[32i+31:32i]` and written to `dst[16i+15:16i]`. `dst[127:64]` takes `dst_prev[127:64]`. `src[255:128]` is ignored.
- R6: With `wide`=1, all eight lanes are converted, and lane order is preserved.
- R7: A finite input whose magnitude exceeds the half range behaves according to its rounding code. Code 0 gives infinity. Code 1 gives 0x7BFF with the sign kept. Code 2 gives negative infinity for negative inputs and 0x7BFF for positive inputs. Code 3 gives positive infinity for positive inputs and 0xFBFF for negative inputs.
- R8: Results below 2^-14 become subnormals or zero, and the bits shifted out take part in rounding. A rounding carry out of the fraction raises the exponent. This can turn a subnormal into the smallest normal, and 0x7BFF into infinity.
- R9: A NaN input gives sign, exponent 31, fraction bit 9 set, and fraction bits 8:0 equal to input fraction bits 22:14. Infinity gives 0x7C00 or 0xFC00.
- R10: Results appear exactly one cycle after `in_valid`, with `out_valid` high for one cycle per accepted request. `dst` holds its value between writes. After reset, `out_valid`, `bad_imm` and `dst` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| wide | input | 1 | 1: convert eight lanes; 0: convert four lanes and merge the upper half |
| src | input | 256 | Packed single-precision lanes, lane 0 in the low bits |
| imm | input | 8 | Per-request rounding immediate |
| imm_en | input | 1 | Take the rounding code from `imm` |
| rc_dflt | input | 2 | Default rounding code |
| dst_prev | input | 128 | Previous destination contents |
| out_valid | output | 1 | Result written this cycle |
| bad_imm | output | 1 | Request rejected for a reserved immediate |
| dst | output | 128 | Packed half-precision result |

## Verification
The bench builds the block with its default of eight lanes. At that size the wide and narrow forms share one instance, so the merge of the upper half and the ignored upper source lanes can be checked against full conversion of the same source. Fixed lane vectors are run under every rounding code: ties on both sides of even, the boundary at 65504 and 65520, the carry from the largest subnormal to the smallest normal, fp32 subnormals, and NaN payloads. Random requests then mix width, immediate, reserved codes and idle gaps.

// File: rtl/f2h_pkg.sv
package f2h_pkg;
  localparam int SP_W   = 32;
  localparam int HP_W   = 16;
  localparam int SP_EXP = 8;
  localparam int SP_FRC = 23;
  localparam int HP_EXP = 5;
  localparam int HP_FRC = 10;
  localparam int REBIAS = 112;
  localparam int ALN_W  = 50;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_DOWN = 2'd2,
    RM_UP   = 2'd3
  } rmode_e;
endpackage

// File: rtl/f2h_mode_sel.sv
module f2h_mode_sel
  import f2h_pkg::*;
(
  input  logic [4:0] imm_lo,
  input  logic       imm_en,
  input  logic [1:0] rc_dflt,
  output rmode_e     mode,
  output logic       reserved
);
  always_comb begin
    reserved = imm_en & (|imm_lo[4:2]);
    mode     = rmode_e'(imm_en ? imm_lo[1:0] : rc_dflt);
  end
endmodule

// File: rtl/f2h_round.sv
module f2h_round
  import f2h_pkg::*;
(
  input  logic              sgn,
  input  logic [HP_EXP-1:0] expb,
  input  logic [HP_FRC-1:0] frac,
  input  logic              grd,
  input  logic              stk,
  input  logic              is_nan,
  input  logic              is_inf,
  input  logic              ovf,
  input  logic [8:0]        payload,
  input  rmode_e            mode,
  output logic [HP_W-1:0]   hp
);
  logic              inexact;
  logic              bump;
  logic              dir_away;
  logic [HP_W-2:0]   mag;

  always_comb begin
    inexact = grd | stk;
    unique case (mode)
      RM_NEAR: bump = grd & (stk | frac[0]);
      RM_ZERO: bump = 1'b0;
      RM_DOWN: bump = sgn & inexact;
      RM_UP:   bump = ~sgn & inexact;
      default: bump = 1'b0;
    endcase
    dir_away = (mode == RM_NEAR) | ((mode == RM_DOWN) & sgn) | ((mode == RM_UP) & ~sgn);
    mag = {expb, frac} + {{(HP_W-2){1'b0}}, bump};

    if (is_nan)      hp = {sgn, {HP_EXP{1'b1}}, 1'b1, payload};
    else if (is_inf) hp = {sgn, {HP_EXP{1'b1}}, {HP_FRC{1'b0}}};
    else if (ovf)    hp = {sgn, dir_away ? 15'h7C00 : 15'h7BFF};
    else             hp = {sgn, mag};
  end
endmodule

// File: rtl/f2h_lane.sv
module f2h_lane
  import f2h_pkg::*;
(
  input  logic [SP_W-1:0] sp,
  input  rmode_e          mode,
  output logic [HP_W-1:0] hp
);
  logic              sgn;
  logic [SP_EXP-1:0] e;
  logic [SP_FRC-1:0] m;
  logic              spec;
  logic signed [9:0] he;
  logic signed [9:0] shd;
  logic [4:0]        sh;
  logic [HP_EXP-1:0] expb;
  logic [SP_FRC:0]   sig;
  logic [ALN_W-1:0]  aligned;
  logic              ovf;
  logic              unused_top;

  always_comb begin
    sgn  = sp[SP_W-1];
    e    = sp[SP_W-2:SP_FRC];
    m    = sp[SP_FRC-1:0];
    spec = &e;
    sig  = {|e, m};
    he   = $signed({2'b00, e}) - 10'sd112;
    shd  = 10'sd1 - he;
    if (he > 10'sd0) begin
      sh   = 5'd0;
      expb = he[HP_EXP-1:0];
    end else begin
      sh   = (shd > 10'sd26) ? 5'd26 : shd[4:0];
      expb = '0;
    end
    ovf     = ~spec & (he > 10'sd30);
    aligned = {sig, 26'd0} >> sh;
  end

  assign unused_top = aligned[ALN_W-1];

  f2h_round u_round (
    .sgn     (sgn),
    .expb    (expb),
    .frac    (aligned[48:39]),
    .grd     (aligned[38]),
    .stk     (|aligned[37:0]),
    .is_nan  (spec & (|m)),
    .is_inf  (spec & ~(|m)),
    .ovf     (ovf),
    .payload (m[22:14]),
    .mode    (mode),
    .hp      (hp)
  );
endmodule

// File: rtl/f2h_narrow.sv
module f2h_narrow
  import f2h_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    wide,
  input  logic [LANES*SP_W-1:0]   src,
  input  logic [7:0]              imm,
  input  logic                    imm_en,
  input  logic [1:0]              rc_dflt,
  input  logic [LANES*HP_W-1:0]   dst_prev,
  output logic                    out_valid,
  output logic                    bad_imm,
  output logic [LANES*HP_W-1:0]   dst
);
  localparam int DST_W  = LANES * HP_W;
  localparam int HALF_W = DST_W / 2;

  rmode_e           mode;
  logic             reserved;
  logic [DST_W-1:0] conv;
  logic [DST_W-1:0] merged;
  logic             write_ok;
  logic             valid_d, bad_d;
  logic [DST_W-1:0] dst_d;
  logic             valid_q, bad_q;
  logic [DST_W-1:0] dst_q;
  logic             unused_bits;

  assign unused_bits = ^{imm[7:5], dst_prev[HALF_W-1:0]};

  f2h_mode_sel u_mode (
    .imm_lo   (imm[4:0]),
    .imm_en   (imm_en),
    .rc_dflt  (rc_dflt),
    .mode     (mode),
    .reserved (reserved)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    f2h_lane u_lane (
      .sp   (src[i*SP_W +: SP_W]),
      .mode (mode),
      .hp   (conv[i*HP_W +: HP_W])
    );
  end

  always_comb begin
    write_ok = in_valid & ~reserved;
    merged   = wide ? conv : {dst_prev[DST_W-1:HALF_W], conv[HALF_W-1:0]};
    valid_d  = write_ok;
    bad_d    = in_valid & reserved;
    dst_d    = write_ok ? merged : dst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      bad_q   <= 1'b0;
      dst_q   <= '0;
    end else begin
      valid_q <= valid_d;
      bad_q   <= bad_d;
      dst_q   <= dst_d;
    end
  end

  assign out_valid = valid_q;
  assign bad_imm   = bad_q;
  assign dst       = dst_q;
endmodule

// File: rtl/f2h_narrow_chk.sv
module f2h_narrow_chk #(
  parameter int LANES = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  wide,
  input logic [7:0]            imm,
  input logic                  imm_en,
  input logic [LANES*16-1:0]   dst_prev,
  input logic                  out_valid,
  input logic                  bad_imm,
  input logic [LANES*16-1:0]   dst
);
  localparam int DW = LANES * 16;
  localparam int HW = DW / 2;

  logic rsv_req;
  assign rsv_req = in_valid && imm_en && (imm[4:0] >= 5'd4);

  // R4
  a_r4_reserved_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_req |=> bad_imm && !out_valid && $stable(dst));

  // R4
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bad_imm && out_valid));

  // R10
  a_r10_result_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rsv_req) |=> out_valid && !bad_imm);

  // R10
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !bad_imm && $stable(dst));

  // R5
  a_r5_upper_merged: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide && !rsv_req) |=> dst[DW-1:HW] == $past(dst_prev[DW-1:HW]));
endmodule

bind f2h_narrow f2h_narrow_chk #(.LANES(LANES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .wide      (wide),
  .imm       (imm),
  .imm_en    (imm_en),
  .dst_prev  (dst_prev),
  .out_valid (out_valid),
  .bad_imm   (bad_imm),
  .dst       (dst)
);

// File: tb/tb_f2h_narrow.sv
`timescale 1ns/1ps
module tb_f2h_narrow;
  localparam int LN = 8;

  logic           clk;
  logic           rst_n;
  logic           in_valid;
  logic           wide;
  logic [255:0]   src;
  logic [7:0]     imm;
  logic           imm_en;
  logic [1:0]     rc_dflt;
  logic [127:0]   dst_prev;
  logic           out_valid;
  logic           bad_imm;
  logic [127:0]   dst;

  int    checks;
  int    failures;
  bit    done;
  string cur_req;
  string m_req;
  logic          m_valid;
  logic          m_bad;
  logic [127:0]  m_dst;

  f2h_narrow #(.LANES(LN)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .wide(wide), .src(src),
    .imm(imm), .imm_en(imm_en), .rc_dflt(rc_dflt), .dst_prev(dst_prev),
    .out_valid(out_valid), .bad_imm(bad_imm), .dst(dst)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Behavioural conversion by exact integer scaling.
  function automatic logic [15:0] ref_h(input logic [31:0] x, input logic [1:0] md);
    logic   sn;
    int     ex, k, top, t, qe, sh;
    longint sig, n, bits;
    bit     g, st, up;
    sn = x[31];
    ex = int'(x[30:23]);
    if (ex == 255) begin
      if (x[22:0] != 0) return {sn, 5'h1f, 1'b1, x[22:14]};
      return {sn, 15'h7c00};
    end
    sig = longint'(x[22:0]);
    if (ex != 0) sig = sig + (longint'(1) << 23);
    if (sig == 0) return {sn, 15'h0};
    k = ((ex == 0) ? 1 : ex) - 150;
    top = 23;
    while (((sig >> top) & 1) == 0) top--;
    t  = k + top;
    qe = (t >= -14) ? t - 10 : -24;
    sh = qe - k;
    if (sh > 40) begin
      n = 0; g = 0; st = 1;
    end else begin
      n  = sig >> sh;
      g  = ((sig >> (sh - 1)) & 1) != 0;
      st = (sig & ((longint'(1) << (sh - 1)) - 1)) != 0;
    end
    case (md)
      2'd0: up = g && (st || n[0]);
      2'd1: up = 0;
      2'd2: up = sn && (g || st);
      default: up = !sn && (g || st);
    endcase
    if (up) n = n + 1;
    bits = (qe == -24) ? n : ((longint'(qe + 25) << 10) + n - 1024);
    if (bits >= 'h7C00)
      bits = (md == 0 || (md == 2 && sn) || (md == 3 && !sn)) ? 'h7C00 : 'h7BFF;
    return {sn, bits[14:0]};
  endfunction

  // Cycle model: expected outputs after each clock edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 1'b0; m_bad = 1'b0; m_dst = '0; m_req = "R10";
    end else begin
      m_req = cur_req;
      if (in_valid) begin
        if (imm_en && imm[4:0] > 5'd3) begin
          m_valid = 1'b0; m_bad = 1'b1;
        end else begin
          logic [1:0] md;
          md = imm_en ? imm[1:0] : rc_dflt;
          m_valid = 1'b1; m_bad = 1'b0;
          for (int i = 0; i < (wide ? 8 : 4); i++)
            m_dst[16*i +: 16] = ref_h(src[32*i +: 32], md);
          if (!wide) m_dst[127:64] = dst_prev[127:64];
        end
      end else begin
        m_valid = 1'b0; m_bad = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(out_valid === m_valid, m_req, "out_valid", 128'(out_valid), 128'(m_valid));
      check(bad_imm === m_bad, m_req, "bad_imm", 128'(bad_imm), 128'(m_bad));
      check(dst === m_dst, m_req, "dst", dst, m_dst);
    end
  end

  task automatic op(input logic w, input logic [255:0] s, input logic [7:0] im,
                    input logic ie, input logic [1:0] rc, input logic [127:0] pv,
                    input string rq);
    @(negedge clk);
    cur_req = rq; in_valid = 1'b1; wide = w; src = s; imm = im;
    imm_en = ie; rc_dflt = rc; dst_prev = pv;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      src = {8{32'hDEADBEEF}};
    end
  endtask

  function automatic logic [31:0] rnd_sp();
    logic [7:0] e;
    int sel;
    sel = $urandom % 8;
    if (sel == 0) e = 8'hFF;
    else if (sel == 1) e = 8'h00;
    else e = 8'(95 + $urandom % 52);
    return {1'($urandom), e, 23'($urandom)};
  endfunction

  logic [255:0] v_near, v_dir, v_ovf, v_sub, v_nan;

  initial begin
    checks = 0; failures = 0; done = 0;
    cur_req = "R10";
    rst_n = 1'b0; in_valid = 1'b0; wide = 1'b0; src = '0; imm = '0;
    imm_en = 1'b0; rc_dflt = 2'd0; dst_prev = '0;
    v_near = {32'h80000000, 32'h00000000, 32'h40490FDB, 32'hBFC00000,
              32'h3F801001, 32'h3F803000, 32'h3F801000, 32'h3F800000};
    v_dir  = {32'hBF801001, 32'h3F801001, 32'hBF803000, 32'h3F803000,
              32'hC0490FDB, 32'h40490FDB, 32'hBF800000, 32'h3F800000};
    v_ovf  = {32'h477FEFFF, 32'hFF7FFFFF, 32'h7F7FFFFF, 32'hC9742400,
              32'h49742400, 32'hC77FF000, 32'h477FF000, 32'h477FE000};
    v_sub  = {32'h33C00000, 32'h38800000, 32'h00000001, 32'h387FE000,
              32'h387FC000, 32'hB3000001, 32'h33000000, 32'h33800000};
    v_nan  = {32'h3F800000, 32'h7FFFFFFF, 32'hFF800000, 32'h7F800000,
              32'hFF812345, 32'h7F800001, 32'h7FC00000, 32'hFFC00000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);                                         // R10 reset state

    op(1, v_near, 8'h00, 0, 2'd0, '0, "R1");
    op(1, v_dir, 8'h00, 0, 2'd0, '0, "R1");
    for (int md = 1; md < 4; md++) op(1, v_dir, 8'h00, 0, 2'(md), '0, "R2");
    op(1, v_dir, 8'hE2, 1, 2'd0, '0, "R3");          // imm overrides default
    op(1, v_dir, 8'hA3, 1, 2'd1, '0, "R3");
    op(1, v_dir, 8'h1F, 0, 2'd3, '0, "R3");          // reserved imm ignored when disabled
    idle(1);
    op(1, v_dir, 8'h04, 1, 2'd0, '0, "R4");
    op(1, v_dir, 8'h1F, 1, 2'd0, '0, "R4");
    idle(2);                                         // R4: dst held after rejects
    op(0, {128'hFFFFFFFF_7F800001_FFFFFFFF_00000000, v_dir[127:0]}, 8'h00, 0, 2'd0,
       128'h0123456789ABCDEF_FEDCBA9876543210, "R5");
    op(0, v_near, 8'h03, 1, 2'd0, 128'hA5A5A5A5A5A5A5A5_5A5A5A5A5A5A5A5A, "R5");
    op(1, {v_near[127:0], v_dir[255:128]}, 8'h00, 0, 2'd0, 128'hFFFF, "R6");
    for (int md = 0; md < 4; md++) op(1, v_ovf, 8'h00, 0, 2'(md), '0, "R7");
    for (int md = 0; md < 4; md++) op(1, v_sub, 8'(md), 1, 2'd0, '0, "R8");
    op(1, v_nan, 8'h00, 0, 2'd2, '0, "R9");
    idle(3);                                         // R10 hold
    for (int n = 0; n < 400; n++) begin
      logic [255:0] s;
      for (int i = 0; i < 8; i++) s[32*i +: 32] = rnd_sp();
      if ($urandom % 5 == 0) idle(1 + $urandom % 3);
      op(1'($urandom), s, ($urandom % 6 == 0) ? 8'($urandom) : 8'($urandom % 4),
         1'($urandom), 2'($urandom), {4{32'($urandom)}}, "R6");
    end
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL R10 watchdog actual=%h expected=%h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule